// File: doc/BRIEF.md
# Galloping-Pattern Memory Self-Test Engine

This block is a hardware self-test controller for a synchronous single-port RAM. It takes a start pulse together with an inclusive address window, then drives the memory's address, write-data, write-enable and read-data ports through a two-pass galloping test. It first fills the window with a uniform background value. In the first pass each cell in turn becomes the test cell and is written with the inverted background. Every other cell is then read and checked, and after each of those reads the test cell is read again to confirm it still holds the inverted value. The test cell is then restored to the background. The second pass repeats the same interleaved read order without any inversion.

The background is all zeros, or all ones when the pattern-select input is high at start. The memory is assumed to return read data one cycle after the address is presented, and the compare stage is pipelined to match. On the first mismatch the engine stops and reports the failing address, the expected word and the word actually read. After a clean run it reports completion with the fail flag low. Results stay on the outputs until the next start.

Top module: `galpat_bist`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and mem_we_o are all low.
- R2: A start pulse accepted while idle raises busy_o in the next cycle. From that cycle on, the engine writes the background to every address from base_i up to limit_i, in ascending order, one write per cycle. The background is 0 when bg_ones_i is low at start and all ones when it is high.
- R3: In the first pass the test cell takes each address of the window in ascending order. For each one the engine first writes the bitwise inverse of the background into it.
- R4: After that inverting write, the engine reads every other cell of the window in ascending order, expecting the background. Each of those reads is followed in the very next cycle by a read of the test cell, expecting the inverted background.
- R5: In the first pass the test cell is written back to the background in the cycle after its last re-read, before the next test cell is inverted.
- R6: When the window has more than one cell, a second pass follows. It uses the same test-cell order and the same interleaved read order, issues no writes, and expects the background from every read, test cell included.
- R7: mem_rdata_i is compared in the cycle after the read address was presented.
- R8: On the first mismatch, busy_o falls in the next cycle and fail_o and done_o rise. fail_addr_o, fail_exp_o and fail_act_o then hold the address, the expected word and the word read. No memory operation is issued after the cycle in which the mismatch was compared.
- R9: After the last read of a clean run, there is one further busy cycle with no memory operation. Then busy_o falls and done_o rises while fail_o stays low.
- R10: A start pulse while busy_o is high has no effect on the operation sequence.
- R11: A window of exactly one cell gets only its fill write, its inverting write and its restore write, with no reads, and then completes cleanly.
- R12: done_o, fail_o and the failure fields hold their values while idle. An accepted start clears done_o and fail_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| bg_ones_i | input | 1 | Background select: 0 gives all zeros, 1 gives all ones |
| base_i | input | ADDR_W | First address of the window |
| limit_i | input | ADDR_W | Last address of the window (inclusive) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after the address |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished, held until next start |
| fail_o | output | 1 | A mismatch was found |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_exp_o | output | DATA_W | Expected word at the first mismatch |
| fail_act_o | output | DATA_W | Word read at the first mismatch |

## Verification
The assertions assume that base_i is not above limit_i when a start is accepted. They also assume that the attached memory answers each read exactly one cycle later and never sees a read and a write in the same cycle. The bench keeps every window ordered and models the RAM with that one-cycle latency. It injects start pulses only while idle, apart from the deliberate start that exercises R10 during a run. Stuck-at and coupling faults are placed inside the window under test, so that every mismatch the engine sees comes from a real read.

// File: rtl/galpat_pkg.sv
package galpat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_INVERT,
        ST_RD_NBR,
        ST_RD_TEST,
        ST_RESTORE,
        ST_DRAIN
    } gp_state_e;

    typedef enum logic [1:0] {
        MOP_NONE,
        MOP_WRITE,
        MOP_READ
    } mem_op_e;

    function automatic logic state_is_read(gp_state_e s);
        return (s == ST_RD_NBR) || (s == ST_RD_TEST);
    endfunction

    function automatic logic state_is_write(gp_state_e s);
        return (s == ST_FILL) || (s == ST_INVERT) || (s == ST_RESTORE);
    endfunction

endpackage

// File: rtl/galpat_seq.sv
module galpat_seq
    import galpat_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              bg_ones_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  logic              mismatch_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              clear_o,
    output mem_op_e           op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rd_exp_o
);
    localparam int AX = ADDR_W + 1;

    gp_state_e         st_q, st_d;
    logic              pass_q, pass_d;
    logic              done_q, done_d;
    logic [ADDR_W-1:0] tcell_q, tcell_d;
    logic [ADDR_W-1:0] ocell_q, ocell_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [ADDR_W-1:0] limit_q, limit_d;
    logic [DATA_W-1:0] bg_q, bg_d;

    logic              has_other;
    logic [ADDR_W-1:0] first_nbr;
    logic [AX-1:0]     n1, n_nbr;
    logic              nbr_last;
    logic              tcell_last;
    logic              advance;

    always_comb begin
        has_other  = (base_q != limit_q);
        first_nbr  = (tcell_q == base_q) ? base_q + 1'b1 : base_q;
        n1         = {1'b0, ocell_q} + 1'b1;
        n_nbr      = (n1 == {1'b0, tcell_q}) ? n1 + 1'b1 : n1;
        nbr_last   = (n_nbr > {1'b0, limit_q});
        tcell_last = (tcell_q == limit_q);
    end

    always_comb begin
        st_d    = st_q;
        pass_d  = pass_q;
        done_d  = done_q;
        tcell_d = tcell_q;
        ocell_d = ocell_q;
        base_d  = base_q;
        limit_d = limit_q;
        bg_d    = bg_q;
        advance = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d    = ST_FILL;
                    ocell_d = base_i;
                    base_d  = base_i;
                    limit_d = limit_i;
                    bg_d    = {DATA_W{bg_ones_i}};
                    pass_d  = 1'b0;
                    done_d  = 1'b0;
                end
            end
            ST_FILL: begin
                if (ocell_q == limit_q) begin
                    tcell_d = base_q;
                    st_d    = ST_INVERT;
                end else begin
                    ocell_d = ocell_q + 1'b1;
                end
            end
            ST_INVERT: begin
                if (has_other) begin
                    st_d    = ST_RD_NBR;
                    ocell_d = first_nbr;
                end else begin
                    st_d = ST_RESTORE;
                end
            end
            ST_RD_NBR: st_d = ST_RD_TEST;
            ST_RD_TEST: begin
                if (!nbr_last) begin
                    st_d    = ST_RD_NBR;
                    ocell_d = n_nbr[ADDR_W-1:0];
                end else if (!pass_q) begin
                    st_d = ST_RESTORE;
                end else begin
                    advance = 1'b1;
                end
            end
            ST_RESTORE: advance = 1'b1;
            ST_DRAIN: begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase

        if (advance) begin
            if (!tcell_last) begin
                tcell_d = tcell_q + 1'b1;
                if (pass_q) begin
                    st_d    = ST_RD_NBR;
                    ocell_d = base_q;
                end else begin
                    st_d = ST_INVERT;
                end
            end else if (!pass_q && has_other) begin
                pass_d  = 1'b1;
                tcell_d = base_q;
                st_d    = ST_RD_NBR;
                ocell_d = base_q + 1'b1;
            end else begin
                st_d = ST_DRAIN;
            end
        end

        if (mismatch_i && st_q != ST_IDLE) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            pass_q  <= 1'b0;
            done_q  <= 1'b0;
            tcell_q <= '0;
            ocell_q <= '0;
            base_q  <= '0;
            limit_q <= '0;
            bg_q    <= '0;
        end else begin
            st_q    <= st_d;
            pass_q  <= pass_d;
            done_q  <= done_d;
            tcell_q <= tcell_d;
            ocell_q <= ocell_d;
            base_q  <= base_d;
            limit_q <= limit_d;
            bg_q    <= bg_d;
        end
    end

    always_comb begin
        busy_o   = (st_q != ST_IDLE);
        done_o   = done_q;
        clear_o  = (st_q == ST_IDLE) && start_i;
        op_o     = MOP_NONE;
        addr_o   = '0;
        wdata_o  = '0;
        rd_exp_o = '0;
        if (state_is_write(st_q)) op_o = MOP_WRITE;
        if (state_is_read(st_q))  op_o = MOP_READ;
        unique case (st_q)
            ST_FILL:    begin addr_o = ocell_q; wdata_o = bg_q;  end
            ST_INVERT:  begin addr_o = tcell_q; wdata_o = ~bg_q; end
            ST_RESTORE: begin addr_o = tcell_q; wdata_o = bg_q;  end
            ST_RD_NBR:  begin addr_o = ocell_q; rd_exp_o = bg_q; end
            ST_RD_TEST: begin addr_o = tcell_q; rd_exp_o = pass_q ? bg_q : ~bg_q; end
            default: ;
        endcase
    end

    // R6: the second pass never writes
    p_pass2_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && pass_q) |-> (op_o != MOP_WRITE));

    // R4: a neighbour read is always followed by a test-cell re-read
    p_nbr_then_test_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RD_NBR && !mismatch_i) |=> (st_q == ST_RD_TEST && addr_o == tcell_q));

    // R2: every access stays inside the latched window
    p_addr_in_window_r2: assert property (@(posedge clk) disable iff (rst)
        (op_o != MOP_NONE) |-> (addr_o >= base_q && addr_o <= limit_q));

    // R9: busy and done are never high together
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !done_o);

endmodule

// File: rtl/galpat_cmp.sv
module galpat_cmp #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              rd_issue_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] rd_exp_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              mismatch_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_exp_o,
    output logic [DATA_W-1:0] fail_act_o
);
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_exp_q;
    logic              fail_q;
    logic [ADDR_W-1:0] faddr_q;
    logic [DATA_W-1:0] fexp_q, fact_q;

    assign mismatch_o = pend_q && !fail_q && (rdata_i != pend_exp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_exp_q  <= '0;
            fail_q      <= 1'b0;
            faddr_q     <= '0;
            fexp_q      <= '0;
            fact_q      <= '0;
        end else begin
            pend_q      <= rd_issue_i && !mismatch_o;
            pend_addr_q <= rd_addr_i;
            pend_exp_q  <= rd_exp_i;
            if (clear_i) begin
                fail_q <= 1'b0;
            end else if (mismatch_o) begin
                fail_q  <= 1'b1;
                faddr_q <= pend_addr_q;
                fexp_q  <= pend_exp_q;
                fact_q  <= rdata_i;
            end
        end
    end

    assign fail_o      = fail_q;
    assign fail_addr_o = faddr_q;
    assign fail_exp_o  = fexp_q;
    assign fail_act_o  = fact_q;

    // R8: a compare miss always sets the fail flag
    p_miss_sets_fail_r8: assert property (@(posedge clk) disable iff (rst)
        (mismatch_o && !clear_i) |=> fail_o);

    // R12: failure record is held until a start clears it
    p_fail_held_r12: assert property (@(posedge clk) disable iff (rst)
        (fail_o && !clear_i) |=> (fail_o && $stable(fail_addr_o) && $stable(fail_act_o)));

endmodule

// File: rtl/galpat_bist.sv
module galpat_bist
    import galpat_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              bg_ones_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_exp_o,
    output logic [DATA_W-1:0] fail_act_o
);
    mem_op_e           op;
    logic              mismatch;
    logic              clear;
    logic [DATA_W-1:0] rd_exp;

    galpat_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .bg_ones_i  (bg_ones_i),
        .base_i     (base_i),
        .limit_i    (limit_i),
        .mismatch_i (mismatch),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .clear_o    (clear),
        .op_o       (op),
        .addr_o     (mem_addr_o),
        .wdata_o    (mem_wdata_o),
        .rd_exp_o   (rd_exp)
    );

    galpat_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cmp_i (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (clear),
        .rd_issue_i  (op == MOP_READ),
        .rd_addr_i   (mem_addr_o),
        .rd_exp_i    (rd_exp),
        .rdata_i     (mem_rdata_i),
        .mismatch_o  (mismatch),
        .fail_o      (fail_o),
        .fail_addr_o (fail_addr_o),
        .fail_exp_o  (fail_exp_o),
        .fail_act_o  (fail_act_o)
    );

    assign mem_we_o = (op == MOP_WRITE);

    // R8: a recorded failure means the engine is stopped
    p_fail_idle_r8: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> !busy_o);

    // R1: writes happen only during a run
    p_we_only_busy_r1: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

endmodule

// File: tb/galpat_bist_tb.sv
`timescale 1ns/1ps
module galpat_bist_tb_top;
    localparam int AW = 6;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic bg_ones = 1'b0;
    logic [AW-1:0] base = '0, limit = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic mem_we, busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp, fail_act;

    always #2.5 clk = ~clk;

    galpat_bist #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .bg_ones_i(bg_ones),
        .base_i(base), .limit_i(limit),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
        .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fail_o(fail),
        .fail_addr_o(fail_addr), .fail_exp_o(fail_exp), .fail_act_o(fail_act)
    );

    // behavioural RAM with injectable faults
    logic [DW-1:0] ram [0:(1<<AW)-1];
    logic          stk_en = 1'b0, stk_val = 1'b0;
    int            stk_addr = 0, stk_bit = 0;
    logic          cpl_en = 1'b0;
    int            cpl_agg = 0, cpl_vic = 0;

    always @(posedge clk) begin
        logic [DW-1:0] rv;
        rv = ram[mem_addr];
        if (stk_en && int'(mem_addr) == stk_addr) rv[stk_bit] = stk_val;
        mem_rdata <= rv;
        if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            if (cpl_en && int'(mem_addr) == cpl_agg)
                ram[cpl_vic][0] <= ~ram[cpl_vic][0];
        end
    end

    int n_checks = 0, n_fail = 0;

    function automatic string tagname(int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  10: return "R10"; 11: return "R11"; default: return "R12";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    typedef struct { int kind; int addr; int data; int tag; } ref_op_t;
    ref_op_t q[$];

    // reference sequence built from the requirements
    task automatic build(input int b, input int l, input bit ones);
        int bg, inv;
        bg  = ones ? 'hFF : 0;
        inv = bg ^ 'hFF;
        q.delete();
        for (int a = b; a <= l; a++) q.push_back('{1, a, bg, 2});
        for (int t = b; t <= l; t++) begin
            q.push_back('{1, t, inv, (b == l) ? 11 : 3});
            for (int o = b; o <= l; o++) if (o != t) begin
                q.push_back('{2, o, bg, 4});
                q.push_back('{2, t, inv, 4});
            end
            q.push_back('{1, t, bg, 5});
        end
        if (b != l)
            for (int t = b; t <= l; t++)
                for (int o = b; o <= l; o++) if (o != t) begin
                    q.push_back('{2, o, bg, 6});
                    q.push_back('{2, t, bg, 6});
                end
        q.push_back('{0, 0, 0, 9});
    endtask

    // runs one test; returns predicted failing address or -1
    task automatic run(input int b, input int l, input bit ones, input int glitch_at,
                       output int got_fail_addr);
        bit pend = 0, miss = 0;
        int pend_addr = 0, pend_exp = 0, m_addr = 0, m_exp = 0, m_act = 0, idx = 0;
        ref_op_t e;
        build(b, l, ones);
        got_fail_addr = -1;
        base = AW'(b); limit = AW'(l); bg_ones = ones; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !fail, "R12", {busy, done, fail}, 3'b100);
        while (q.size() > 0) begin
            e = q.pop_front();
            start = (idx == glitch_at);
            if (e.kind == 1)
                chk(busy && mem_we && int'(mem_addr) == e.addr && int'(mem_wdata) == e.data,
                    tagname(e.tag), {busy, mem_we, mem_addr, mem_wdata}, {2'b11, AW'(e.addr), DW'(e.data)});
            else if (e.kind == 2)
                chk(busy && !mem_we && int'(mem_addr) == e.addr,
                    tagname(e.tag), {busy, mem_we, mem_addr}, {2'b10, AW'(e.addr)});
            else
                chk(busy && !mem_we, "R9", {busy, mem_we}, 2'b10);
            if (glitch_at >= 0 && idx == glitch_at + 1)
                chk(busy, "R10", busy, 1);
            if (pend) begin
                if (int'(mem_rdata) != pend_exp) begin
                    miss = 1; m_addr = pend_addr; m_exp = pend_exp; m_act = int'(mem_rdata);
                end
                pend = 0;
            end
            if (e.kind == 2) begin pend = 1; pend_addr = e.addr; pend_exp = e.data; end
            idx++;
            @(negedge clk);
            start = 1'b0;
            if (miss) break;
        end
        if (miss) begin
            chk(!busy && fail && done, "R8", {busy, fail, done}, 3'b011);
            chk(int'(fail_addr) == m_addr && int'(fail_exp) == m_exp && int'(fail_act) == m_act,
                "R7", {fail_addr, fail_exp, fail_act}, {AW'(m_addr), DW'(m_exp), DW'(m_act)});
            got_fail_addr = m_addr;
            @(negedge clk);
            chk(!mem_we && !busy, "R8", {mem_we, busy}, 0);
            repeat (3) @(negedge clk);
            chk(fail && int'(fail_addr) == m_addr, "R12", fail_addr, m_addr);
        end else begin
            chk(!busy && done && !fail, "R9", {busy, done, fail}, 3'b010);
            @(negedge clk);
            chk(done && !busy, "R12", {done, busy}, 2'b10);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int fa;
        for (int i = 0; i < (1 << AW); i++) ram[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fail && !mem_we, "R1", {busy, done, fail, mem_we}, 0);

        run(4, 11, 1'b0, -1, fa);              // clean, zeros
        chk(fa == -1, "R6", fa, -1);
        run(0, 5, 1'b1, -1, fa);               // clean, ones
        chk(fa == -1, "R2", fa, -1);
        run(9, 9, 1'b0, -1, fa);               // single cell
        chk(fa == -1, "R11", fa, -1);
        run(2, 7, 1'b0, 9, fa);                // start while busy
        chk(fa == -1, "R10", fa, -1);

        stk_en = 1; stk_addr = 3; stk_bit = 7; stk_val = 1;
        run(0, 7, 1'b0, -1, fa);               // stuck-at-1 at cell 3
        chk(fa == 3 && fail_act == 8'h80, "R8", {fail_addr, fail_act}, {6'd3, 8'h80});
        stk_en = 0;

        cpl_en = 1; cpl_agg = 2; cpl_vic = 5;
        run(0, 7, 1'b0, -1, fa);               // coupling 2 -> 5
        chk(fa == 5 && fail_act == 8'h01, "R3", {fail_addr, fail_act}, {6'd5, 8'h01});
        cpl_en = 0;

        run(1, 4, 1'b1, -1, fa);               // rerun clears fail
        chk(fa == -1 && !fail, "R12", fail, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule